// File: doc/BRIEF.md
# Reset Source and Status Controller

This block merges every reset request of a small controller into one synchronous system reset and remembers what caused it. Three requests are gathered: an active-low external reset pin, a brown-out comparator and a watchdog time-out. The pin passes through a two-flop synchronizer and a glitch filter, so only a low level held for enough clock samples counts. Once any request is seen, the reset output stays high while requests remain and for a fixed stretch of clocks afterwards. It then releases on a clock edge.

A read-only status byte records the cause of the most recent reset. It also records a stop-mode recovery, which is either a wake pulse without reset or a pin reset taken while stopped. Any bus read of that byte clears its four event bits. A bus write to the same address never reaches the status byte; it is forwarded to the external watchdog control register as a write strobe with data. A low-voltage flag in the byte follows the supply comparator live and is never latched. A rising edge of that level can raise a one-cycle interrupt. Turning the brown-out detector off silences brown-out resets, the flag and the interrupt.

The sequencer has three states. `ST_RUN` means no reset is active. `ST_HOLD` means at least one request is present. `ST_STRETCH` counts the clocks after the last request. The transitions are as follows. RUN→HOLD happens on any request, and that is the capture point for the cause. HOLD→STRETCH happens when all requests drop. STRETCH→HOLD happens when a request returns. STRETCH→RUN happens when the count completes. Power-on reset puts the sequencer in `ST_STRETCH` with a zero count.

Top module: `reset_cause_unit`

## Requirements
- R1: The external pin causes a reset only when its synchronized value is low for at least FILT_LEN consecutive clock samples; a shorter low pulse causes no reset and leaves the status byte unchanged.
- R2: A pin reset taken while `in_stop` is high sets both bit 6 (stop recovery) and bit 4 (pin) of the status byte.
- R3: `sys_rst` is high in every cycle after one in which a request is present. It stays high for STRETCH_LEN cycles after the last cycle with a request, so an L-cycle watchdog pulse gives L+STRETCH_LEN cycles of reset. After `por_n` releases, it stays high for STRETCH_LEN cycles.
- R4: Status bit 7 marks power-on or brown-out, bit 5 marks watchdog and bit 4 marks pin. At most one of them is set. Requests that arrive in the same cycle are ranked brown-out, then watchdog, then pin. Power-on leaves the byte at 0x80.
- R5: A `stop_wake` pulse while no reset is active sets the byte's event bits to bit 6 only (0x40 with the flag low).
- R6: A read at REG_ADDR returns the status byte on `bus_rdata`, with bits 2..0 zero. It clears bits 7..4 from the next cycle on. A read at any other address returns zero and clears nothing.
- R7: A write at REG_ADDR drives `wdt_ctl_we` high with `wdt_ctl_data` equal to `bus_wdata` in the same cycle and leaves the status byte unchanged. A write at any other address gives no strobe.
- R8: Status bit 3 is 1 exactly while the synchronized supply comparator reports low voltage and brown-out detection is enabled. Reads and writes do not change it, and it returns to 0 when the condition ends.
- R9: When `lvd_irq_en` is set, each rising edge of the gated low-voltage level gives exactly one `lvd_irq` pulse of one cycle. This includes a dip of one cycle. When `lvd_irq_en` is clear, there is no pulse.
- R10: With `bod_enable` low, a brown-out indication causes no reset, bit 3 stays 0 and `lvd_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| brownout_det | input | 1 | Brown-out comparator output (synchronous) |
| bod_enable | input | 1 | Brown-out and low-voltage detection enable |
| wdt_timeout | input | 1 | Watchdog time-out request |
| in_stop | input | 1 | Device is in stop mode |
| stop_wake | input | 1 | Stop-mode recovery without reset, one-cycle pulse |
| lvd_below | input | 1 | Low-voltage comparator output, asynchronous |
| lvd_irq_en | input | 1 | Low-voltage interrupt enable |
| bus_addr | input | ADDR_W | Register bus address |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| wdt_ctl_we | output | 1 | Watchdog control write strobe |
| wdt_ctl_data | output | 8 | Watchdog control write data |
| sys_rst | output | 1 | System reset, active high |
| lvd_irq | output | 1 | Low-voltage interrupt pulse |

## Verification
The bench sweeps pin pulse widths around the filter length. A filter that is off by one would reset on a pulse one sample too short, or miss the shortest valid one. It times the reset stretch for watchdog pulses of several lengths and after power-on. A counter that reloads on the wrong edge shows up there as a reset one cycle too long or too short. It fires all seven combinations of simultaneous requests, which exposes a wrong priority or a byte with more than one cause bit set. It also checks that a read clears the event bits while the live low-voltage flag survives reads and writes. A design that latched the flag, or let writes touch the byte, would fail those reads. The enable grid, together with a single-cycle dip, catches interrupts that are missed, doubled or left ungated.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_STRETCH = 2'd2
    } rst_state_e;

    // Event bits of the status byte, bit 7 down to bit 4.
    typedef struct packed {
        logic pwr;   // power-on or brown-out
        logic stop;  // stop-mode recovery
        logic wdt;   // watchdog time-out
        logic pin;   // external pin
    } cause_t;

    localparam cause_t CAUSE_POWER = '{pwr: 1'b1, stop: 1'b0, wdt: 1'b0, pin: 1'b0};
    localparam cause_t CAUSE_WAKE  = '{pwr: 1'b0, stop: 1'b1, wdt: 1'b0, pin: 1'b0};
    localparam cause_t CAUSE_NONE  = '0;

endpackage

// File: rtl/rcu_pin_filter.sv
module rcu_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_req
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    logic       sync1_q, sync2_q;
    logic [CW-1:0] low_cnt_q;

    // Two-flop synchronizer, idles high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= pin_n;
            sync2_q <= sync1_q;
        end
    end

    // Count consecutive low samples; saturate at FILT_LEN; any high sample restarts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (sync2_q) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != FULL) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign pin_req = (low_cnt_q == FULL);

endmodule

// File: rtl/rcu_sequencer.sv
module rcu_sequencer
    import rcu_pkg::*;
#(
    parameter int STRETCH_LEN = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bo_req,
    input  logic   wdt_req,
    input  logic   pin_req,
    input  logic   in_stop,
    input  logic   stop_wake,
    output logic   sys_rst,
    output logic   capture,
    output cause_t cause,
    output logic   wake_evt
);
    localparam int CW = (STRETCH_LEN > 2) ? $clog2(STRETCH_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(STRETCH_LEN - 1);

    rst_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          any_req;

    assign any_req = bo_req | wdt_req | pin_req;

    // State register and stretch counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STRETCH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_STRETCH && state_d == ST_STRETCH) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (any_req) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!any_req) state_d = ST_STRETCH;
            end
            ST_STRETCH: begin
                if (any_req)            state_d = ST_HOLD;
                else if (cnt_q == LAST) state_d = ST_RUN;
            end
            default: state_d = ST_STRETCH;
        endcase
    end

    // Outputs.
    always_comb begin
        sys_rst  = 1'b1;
        capture  = 1'b0;
        wake_evt = 1'b0;
        cause    = CAUSE_NONE;
        unique case (state_q)
            ST_RUN: begin
                sys_rst  = 1'b0;
                capture  = any_req;
                wake_evt = !any_req && stop_wake;
                if (bo_req) begin
                    cause.pwr = 1'b1;
                end else if (wdt_req) begin
                    cause.wdt = 1'b1;
                end else if (pin_req) begin
                    cause.pin  = 1'b1;
                    cause.stop = in_stop;
                end
            end
            ST_HOLD, ST_STRETCH: begin
                sys_rst = 1'b1;
            end
            default: sys_rst = 1'b1;
        endcase
    end

endmodule

// File: rtl/rcu_status.sv
module rcu_status
    import rcu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  cause_t     cause,
    input  logic       wake_evt,
    input  logic       rd_hit,
    input  logic       lvd_live,
    output logic [7:0] status
);
    cause_t evt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= CAUSE_POWER;
        end else if (capture) begin
            evt_q <= cause;
        end else if (wake_evt) begin
            evt_q <= CAUSE_WAKE;
        end else if (rd_hit) begin
            evt_q <= CAUSE_NONE;
        end
    end

    assign status = {evt_q, lvd_live, 3'b000};

endmodule

// File: rtl/rcu_lvd.sv
module rcu_lvd (
    input  logic clk,
    input  logic rst_n,
    input  logic lvd_below,
    input  logic bod_enable,
    input  logic irq_en,
    output logic lvd_live,
    output logic irq
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= lvd_below;
            s2_q   <= s1_q;
            prev_q <= lvd_live;
        end
    end

    assign lvd_live = bod_enable & s2_q;
    assign irq      = irq_en & lvd_live & ~prev_q;

endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
    import rcu_pkg::*;
#(
    parameter int          FILT_LEN    = 4,
    parameter int          STRETCH_LEN = 16,
    parameter int          ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3C
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              brownout_det,
    input  logic              bod_enable,
    input  logic              wdt_timeout,
    input  logic              in_stop,
    input  logic              stop_wake,
    input  logic              lvd_below,
    input  logic              lvd_irq_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              wdt_ctl_we,
    output logic [7:0]        wdt_ctl_data,
    output logic              sys_rst,
    output logic              lvd_irq
);
    logic       pin_req, bo_req, capture, wake_evt, lvd_live;
    logic       addr_hit, rd_hit, wr_hit;
    cause_t     cause;
    logic [7:0] status;

    assign bo_req   = brownout_det & bod_enable;
    assign addr_hit = (bus_addr == REG_ADDR);
    assign rd_hit   = addr_hit & bus_rd;
    assign wr_hit   = addr_hit & bus_wr;

    rcu_pin_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk     (clk),
        .rst_n   (por_n),
        .pin_n   (ext_rst_n),
        .pin_req (pin_req)
    );

    rcu_sequencer #(.STRETCH_LEN(STRETCH_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (por_n),
        .bo_req    (bo_req),
        .wdt_req   (wdt_timeout),
        .pin_req   (pin_req),
        .in_stop   (in_stop),
        .stop_wake (stop_wake),
        .sys_rst   (sys_rst),
        .capture   (capture),
        .cause     (cause),
        .wake_evt  (wake_evt)
    );

    rcu_status u_status (
        .clk      (clk),
        .rst_n    (por_n),
        .capture  (capture),
        .cause    (cause),
        .wake_evt (wake_evt),
        .rd_hit   (rd_hit),
        .lvd_live (lvd_live),
        .status   (status)
    );

    rcu_lvd u_lvd (
        .clk        (clk),
        .rst_n      (por_n),
        .lvd_below  (lvd_below),
        .bod_enable (bod_enable),
        .irq_en     (lvd_irq_en),
        .lvd_live   (lvd_live),
        .irq        (lvd_irq)
    );

    assign bus_rdata    = rd_hit ? status : 8'h00;
    assign wdt_ctl_we   = wr_hit;
    assign wdt_ctl_data = bus_wdata;

endmodule

// File: rtl/reset_cause_unit_chk.sv
module reset_cause_unit_chk (
    input logic       clk,
    input logic       por_n,
    input logic       sys_rst,
    input logic       bo_req,
    input logic       wdt_timeout,
    input logic       pin_req,
    input logic [7:0] status,
    input logic       capture,
    input logic       wake_evt,
    input logic       rd_hit,
    input logic       wr_hit,
    input logic       lvd_irq,
    input logic       bod_enable,
    input logic       lvd_irq_en
);
    p_req_holds_rst_r3: assert property (@(posedge clk) disable iff (!por_n)
        (bo_req || wdt_timeout || pin_req) |=> sys_rst);

    p_one_cause_r4: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({status[7], status[5], status[4]}));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!por_n)
        (rd_hit && !capture && !wake_evt) |=> (status[7:4] == 4'h0));

    p_write_keeps_r7: assert property (@(posedge clk) disable iff (!por_n)
        (wr_hit && !rd_hit && !capture && !wake_evt) |=> $stable(status[7:4]));

    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!por_n)
        lvd_irq |=> !lvd_irq);

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!por_n)
        lvd_irq |-> (bod_enable && lvd_irq_en));

endmodule

bind reset_cause_unit reset_cause_unit_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst     (sys_rst),
    .bo_req      (bo_req),
    .wdt_timeout (wdt_timeout),
    .pin_req     (pin_req),
    .status      (status),
    .capture     (capture),
    .wake_evt    (wake_evt),
    .rd_hit      (rd_hit),
    .wr_hit      (wr_hit),
    .lvd_irq     (lvd_irq),
    .bod_enable  (bod_enable),
    .lvd_irq_en  (lvd_irq_en)
);

// File: tb/reset_cause_unit_test.sv
module reset_cause_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 4;
    localparam int STRETCH    = 6;
    localparam logic [7:0] ADDR = 8'h3C;

    logic       clk = 1'b0;
    logic       por_n, ext_rst_n, brownout_det, bod_enable, wdt_timeout;
    logic       in_stop, stop_wake, lvd_below, lvd_irq_en;
    logic [7:0] bus_addr, bus_wdata, bus_rdata, wdt_ctl_data;
    logic       bus_rd, bus_wr, wdt_ctl_we, sys_rst, lvd_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    reset_cause_unit #(
        .FILT_LEN(FILT), .STRETCH_LEN(STRETCH), .ADDR_W(8), .REG_ADDR(ADDR)
    ) uut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .brownout_det(brownout_det),
        .bod_enable(bod_enable), .wdt_timeout(wdt_timeout), .in_stop(in_stop),
        .stop_wake(stop_wake), .lvd_below(lvd_below), .lvd_irq_en(lvd_irq_en),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_ctl_we(wdt_ctl_we), .wdt_ctl_data(wdt_ctl_data),
        .sys_rst(sys_rst), .lvd_irq(lvd_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_release();
        for (int i = 0; i < 200 && sys_rst; i++) @(negedge clk);
    endtask

    // Pulse the watchdog for len cycles; return cycles with sys_rst high.
    task automatic wdt_pulse(input int len, output int n);
        n = 0;
        wdt_timeout = 1'b1;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (i == len) wdt_timeout = 1'b0;
            #1 if (sys_rst) n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        por_n = 1'b0; ext_rst_n = 1'b1; brownout_det = 1'b0; bod_enable = 1'b1;
        wdt_timeout = 1'b0; in_stop = 1'b0; stop_wake = 1'b0; lvd_below = 1'b0;
        lvd_irq_en = 1'b0; bus_addr = 8'h00; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
        repeat (3) @(negedge clk);
        #1 check("R3 reset during power-on", sys_rst, 1);
        @(negedge clk);
        por_n = 1'b1;
        n = 0;
        for (int i = 0; i < 60; i++) begin
            #1 if (sys_rst) n++;
            @(negedge clk);
        end
        check("R3 power-on stretch", n, STRETCH);
        read_at(ADDR, v);
        check("R4 power-on cause", v, 8'h80);
        read_at(ADDR, v);
        check("R6 read clears", v, 8'h00);

        // R1: glitch filter sweep
        for (int w = 1; w <= FILT + 2; w++) begin
            ext_rst_n = 1'b0;
            n = 0;
            for (int i = 1; i <= 60; i++) begin
                @(negedge clk);
                if (i == w) ext_rst_n = 1'b1;
                #1 if (sys_rst) n++;
            end
            check($sformatf("R1 pin width %0d", w), (n > 0), (w >= FILT));
            read_at(ADDR, v);
            check($sformatf("R1 status width %0d", w), v, (w >= FILT) ? 8'h10 : 8'h00);
        end

        // R3: stretch after watchdog pulses of several lengths
        for (int len = 1; len <= 3; len++) begin
            wdt_pulse(len, n);
            check($sformatf("R3 stretch len %0d", len), n, len + STRETCH);
            read_at(ADDR, v);
            check("R4 watchdog cause", v, 8'h20);
        end

        // R4: priority sweep (bit0 pin, bit1 watchdog, bit2 brown-out)
        for (int m = 1; m < 8; m++) begin
            ext_rst_n = !m[0];
            repeat (2 + FILT) @(negedge clk);
            wdt_timeout  = m[1];
            brownout_det = m[2];
            @(negedge clk);
            wdt_timeout = 1'b0; brownout_det = 1'b0; ext_rst_n = 1'b1;
            #1 check($sformatf("R3 reset mask %0d", m), sys_rst, 1);
            wait_release();
            read_at(ADDR, v);
            check($sformatf("R4 priority mask %0d", m), v,
                  m[2] ? 8'h80 : (m[1] ? 8'h20 : 8'h10));
        end

        // R5: stop wake without reset
        stop_wake = 1'b1;
        @(negedge clk);
        stop_wake = 1'b0;
        #1 check("R5 no reset on wake", sys_rst, 0);
        read_at(ADDR, v);
        check("R5 wake status", v, 8'h40);

        // R2: pin reset in stop mode
        in_stop = 1'b1;
        ext_rst_n = 1'b0;
        repeat (FILT + 1) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        in_stop = 1'b0;
        wait_release();
        read_at(ADDR, v);
        check("R2 stop pin status", v, 8'h50);

        // R6/R7: address decode and write path
        wdt_pulse(1, n);
        read_at(ADDR + 8'h01, v);
        check("R6 other address reads zero", v, 8'h00);
        bus_addr = ADDR; bus_wdata = 8'hA5; bus_wr = 1'b1;
        #1 check("R7 write strobe", wdt_ctl_we, 1);
        check("R7 write data", wdt_ctl_data, 8'hA5);
        @(negedge clk);
        bus_addr = ADDR + 8'h02;
        #1 check("R7 no strobe other address", wdt_ctl_we, 0);
        @(negedge clk);
        bus_wr = 1'b0;
        read_at(ADDR, v);
        check("R7 write leaves status", v, 8'h20);

        // R8/R9/R10: low-voltage enable grid
        for (int g = 0; g < 4; g++) begin
            bod_enable = g[1];
            lvd_irq_en = g[0];
            @(negedge clk);
            lvd_below = 1'b1;
            n = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                #1 if (lvd_irq) n++;
            end
            check($sformatf("R9 irq count grid %0d", g), n, g[1] & g[0]);
            read_at(ADDR, v);
            check($sformatf("R8 flag grid %0d", g), v[3], g[1]);
            bus_addr = ADDR; bus_wr = 1'b1; bus_wdata = 8'hFF;
            @(negedge clk);
            bus_wr = 1'b0;
            read_at(ADDR, v);
            check($sformatf("R8 flag survives access %0d", g), v, g[1] ? 8'h08 : 8'h00);
            lvd_below = 1'b0;
            repeat (3) @(negedge clk);
            read_at(ADDR, v);
            check($sformatf("R8 flag falls %0d", g), v[3], 0);
        end

        // R9: a single-cycle dip still gives one pulse
        bod_enable = 1'b1; lvd_irq_en = 1'b1;
        lvd_below = 1'b1;
        @(negedge clk);
        lvd_below = 1'b0;
        n = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1 if (lvd_irq) n++;
        end
        check("R9 short dip pulse", n, 1);

        // R10: brown-out ignored while detection disabled
        bod_enable = 1'b0;
        brownout_det = 1'b1;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #1 if (sys_rst) n++;
        end
        brownout_det = 1'b0;
        check("R10 no brown-out reset", n, 0);
        bod_enable = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule